// File: doc/BRIEF.md
# Interrupt-Level Flag Context Bank

This block keeps the arithmetic status flags (carry, sign, zero) of a small 8-bit controller. There is one flag set for normal execution and one for each of the four interrupt priority levels. The sets are never cleared. Whichever context is running sees and updates only its own set. On interrupt entry the running context switches to the set that belongs to the entered level. On return-from-interrupt the interrupted context, and with it its flag set, becomes active again without any software action.

The block never saves or restores flags. A small level stack records only which context was interrupted. Flag values stay where they are. A level therefore starts each service with the flags it held when it last exited. Subroutine call and return belong to normal execution and leave every set untouched.

A controller FSM has two states: `CTX_NORMAL`, where normal execution owns the flags, and `CTX_SERVICE`, where an interrupt level owns them. Its transitions are:
- `ENTER` (NORMAL→SERVICE): an accepted entry from normal mode.
- `NEST` (SERVICE→SERVICE): an accepted entry while a level is being served.
- `RESUME` (SERVICE→SERVICE): a return that pops a level index.
- `LEAVE` (SERVICE→NORMAL): a return that pops the normal index.
- `STRAY` (NORMAL→NORMAL): a return with an empty stack. It only sets the error bit.

Top module: `irq_flag_ctx`

## Requirements
- R1: After reset the active context is normal (index 0), `in_service` is 0, every flag set is all zero and `ret_err` is 0.
- R2: When `alu_we` is high, the active context's set takes carry = `alu_ovf`, sign = `alu_unf` and zero = `alu_zero`. The new values are visible from the next cycle, and no other set changes.
- R3: An accepted `irq_enter` with level L (0..3) makes context L+1 active from the next cycle and sets `in_service`. The interrupted context index is pushed onto the level stack.
- R4: `irq_return` with a non-empty stack pops the stack and makes the popped context active from the next cycle. When that context is normal, `in_service` clears and the normal flags are shown again.
- R5: A flag set is never cleared by a context switch. A level entered again shows the values it held when it last exited.
- R6: `sub_call` and `sub_ret` change no flag set, no context and no error state.
- R7: `irq_return` with an empty stack changes no context and no flags, and sets `ret_err`. `ret_err` then stays 1 until reset.
- R8: `irq_enter` while the stack already holds 5 entries is ignored: the context and the flags stay as they were.
- R9: Reading address 8'h26 returns carry in bit 0, sign in bit 1 and zero in bit 2 of the active set, with bits 7:3 at 0. Any other address reads 0. The read path is combinational.
- R10: When `irq_enter` and `irq_return` are high in the same cycle, the entry is taken and the return is dropped. A flag write in a switching cycle goes to the context that was active in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alu_we | input | 1 | Flag update enable |
| alu_ovf | input | 1 | Arithmetic overflow, sets carry |
| alu_unf | input | 1 | Arithmetic underflow, sets sign |
| alu_zero | input | 1 | Zero result |
| irq_enter | input | 1 | Interrupt entry pulse |
| irq_level | input | 2 | Level of the entered interrupt |
| irq_return | input | 1 | Return-from-interrupt pulse |
| sub_call | input | 1 | Subroutine call pulse |
| sub_ret | input | 1 | Subroutine return pulse |
| rd_addr | input | 8 | Input-register read address |
| flag_carry | output | 1 | Active carry |
| flag_sign | output | 1 | Active sign |
| flag_zero | output | 1 | Active zero |
| in_service | output | 1 | An interrupt level is active |
| active_ctx | output | 3 | Active context index (0 normal, L+1 for level L) |
| rd_data | output | 8 | Read data |
| ret_err | output | 1 | Sticky stray-return error |

## Verification
The flags, `active_ctx`, `in_service` and `ret_err` all come from registers, so each is due exactly one rising edge after the stimulus that causes it. `rd_data` follows `rd_addr` combinationally, but its value comes from the active set as it stands after that same edge. The bench drives each stimulus at a falling edge and compares every output at the next falling edge. The reference model is updated in the same order the edge applies the change: the write to the old context first, then the switch.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    typedef enum logic [0:0] {
        CTX_NORMAL  = 1'b0,
        CTX_SERVICE = 1'b1
    } ctx_state_e;

    typedef struct packed {
        logic zero;
        logic sign;
        logic carry;
    } flag_set_t;

    localparam flag_set_t FLAGS_CLEAR = '{zero: 1'b0, sign: 1'b0, carry: 1'b0};

endpackage

// File: rtl/flag_bank.sv
module flag_bank
    import irq_flag_pkg::*;
#(
    parameter int NUM_CTX = 5,
    parameter int CTX_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] sel,
    input  flag_set_t        wr_data,
    output flag_set_t        rd_data
);

    flag_set_t sets [NUM_CTX];

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sets[g] <= FLAGS_CLEAR;
            end else if (wr_en && (sel == CTX_W'(g))) begin
                sets[g] <= wr_data;
            end
        end

        // R2 / R5: a set that is not selected keeps its value.
        assert_other_sets_hold_R5: assert property (
            @(posedge clk) disable iff (!rst_n)
            (sel != CTX_W'(g)) |=> $stable(sets[g])
        );
    end

    always_comb begin
        rd_data = FLAGS_CLEAR;
        for (int i = 0; i < NUM_CTX; i++) begin
            if (sel == CTX_W'(i)) begin
                rd_data = sets[i];
            end
        end
    end

endmodule

// File: rtl/level_stack.sv
module level_stack #(
    parameter int DEPTH = 5,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] push_data,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);

    localparam int SP_W = $clog2(DEPTH + 1);

    logic [SP_W-1:0] sp;
    logic [W-1:0]    mem [DEPTH];

    assign empty = (sp == '0);
    assign full  = (sp == SP_W'(DEPTH));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp <= '0;
        end else if (push) begin
            sp <= sp + 1'b1;
        end else if (pop) begin
            sp <= sp - 1'b1;
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (push && (sp == SP_W'(g))) begin
                mem[g] <= push_data;
            end
        end
    end

    always_comb begin
        top = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (sp == SP_W'(i + 1)) begin
                top = mem[i];
            end
        end
    end

    assert_no_pop_empty_R7: assert property (
        @(posedge clk) disable iff (!rst_n) !(pop && empty)
    );

    assert_no_push_full_R8: assert property (
        @(posedge clk) disable iff (!rst_n) !(push && full)
    );

endmodule

// File: rtl/ctx_fsm.sv
module ctx_fsm
    import irq_flag_pkg::*;
#(
    parameter int CTX_W = 3,
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enter,
    input  logic [LVL_W-1:0] level,
    input  logic             ret,
    input  logic             stk_empty,
    input  logic             stk_full,
    input  logic [CTX_W-1:0] stk_top,
    output logic             push,
    output logic             pop,
    output logic [CTX_W-1:0] cur_ctx,
    output logic             in_service,
    output logic             err
);

    ctx_state_e       state_q, state_d;
    logic [CTX_W-1:0] ctx_d;
    logic             take_enter, take_ret, stray_ret;

    // Entry has priority over a return in the same cycle (R10).
    assign take_enter = enter && !stk_full;
    assign take_ret   = ret && !enter && !stk_empty;
    assign stray_ret  = ret && !enter && stk_empty;

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CTX_NORMAL;
            cur_ctx <= '0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            cur_ctx <= ctx_d;
            err     <= err | stray_ret;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        ctx_d   = cur_ctx;
        unique case (state_q)
            CTX_NORMAL: begin
                if (take_enter) begin            // ENTER
                    state_d = CTX_SERVICE;
                    ctx_d   = CTX_W'(level) + CTX_W'(1);
                end
            end
            CTX_SERVICE: begin
                if (take_enter) begin            // NEST
                    ctx_d = CTX_W'(level) + CTX_W'(1);
                end else if (take_ret) begin
                    ctx_d = stk_top;
                    if (stk_top == '0) begin     // LEAVE
                        state_d = CTX_NORMAL;
                    end                          // else RESUME
                end
            end
            default: begin
                state_d = CTX_NORMAL;
                ctx_d   = '0;
            end
        endcase
    end

    // Outputs.
    always_comb begin
        push       = take_enter;
        pop        = take_ret;
        in_service = (state_q == CTX_SERVICE);
    end

    assert_enter_selects_level_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
        (enter && !stk_full) |=> (cur_ctx == CTX_W'($past(level)) + CTX_W'(1)) && in_service
    );

    assert_stray_sets_err_R7: assert property (
        @(posedge clk) disable iff (!rst_n)
        (ret && !enter && stk_empty) |=> err && $stable(cur_ctx)
    );

    assert_err_sticky_R7: assert property (
        @(posedge clk) disable iff (!rst_n) err |=> err
    );

    assert_full_enter_ignored_R8: assert property (
        @(posedge clk) disable iff (!rst_n)
        (enter && stk_full) |=> $stable(cur_ctx)
    );

endmodule

// File: rtl/flag_readout.sv
module flag_readout
    import irq_flag_pkg::*;
#(
    parameter int                ADDR_W     = 8,
    parameter int                DATA_W     = 8,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR = 8'h26
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  flag_set_t         flags,
    output logic [DATA_W-1:0] rd_data
);

    always_comb begin
        rd_data = '0;
        if (rd_addr == FLAGS_ADDR) begin
            rd_data[0] = flags.carry;
            rd_data[1] = flags.sign;
            rd_data[2] = flags.zero;
        end
    end

endmodule

// File: rtl/irq_flag_ctx.sv
module irq_flag_ctx
    import irq_flag_pkg::*;
#(
    parameter int                NUM_LEVELS  = 4,
    parameter int                STACK_DEPTH = 5,
    parameter int                ADDR_W      = 8,
    parameter int                DATA_W      = 8,
    parameter logic [ADDR_W-1:0] FLAGS_ADDR  = 8'h26,
    localparam int               NUM_CTX     = NUM_LEVELS + 1,
    localparam int               CTX_W       = $clog2(NUM_CTX),
    localparam int               LVL_W       = $clog2(NUM_LEVELS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alu_we,
    input  logic              alu_ovf,
    input  logic              alu_unf,
    input  logic              alu_zero,
    input  logic              irq_enter,
    input  logic [LVL_W-1:0]  irq_level,
    input  logic              irq_return,
    input  logic              sub_call,
    input  logic              sub_ret,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              flag_carry,
    output logic              flag_sign,
    output logic              flag_zero,
    output logic              in_service,
    output logic [CTX_W-1:0]  active_ctx,
    output logic [DATA_W-1:0] rd_data,
    output logic              ret_err
);

    logic             stk_push, stk_pop, stk_empty, stk_full;
    logic [CTX_W-1:0] stk_top;
    flag_set_t        wr_set, cur_set;

    assign wr_set = '{zero: alu_zero, sign: alu_unf, carry: alu_ovf};

    ctx_fsm #(.CTX_W(CTX_W), .LVL_W(LVL_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .enter      (irq_enter),
        .level      (irq_level),
        .ret        (irq_return),
        .stk_empty  (stk_empty),
        .stk_full   (stk_full),
        .stk_top    (stk_top),
        .push       (stk_push),
        .pop        (stk_pop),
        .cur_ctx    (active_ctx),
        .in_service (in_service),
        .err        (ret_err)
    );

    level_stack #(.DEPTH(STACK_DEPTH), .W(CTX_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (stk_push),
        .pop       (stk_pop),
        .push_data (active_ctx),
        .top       (stk_top),
        .empty     (stk_empty),
        .full      (stk_full)
    );

    flag_bank #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alu_we),
        .sel     (active_ctx),
        .wr_data (wr_set),
        .rd_data (cur_set)
    );

    flag_readout #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .FLAGS_ADDR(FLAGS_ADDR)) u_rd (
        .rd_addr (rd_addr),
        .flags   (cur_set),
        .rd_data (rd_data)
    );

    assign flag_carry = cur_set.carry;
    assign flag_sign  = cur_set.sign;
    assign flag_zero  = cur_set.zero;

    assert_call_ret_inert_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        ((sub_call || sub_ret) && !alu_we && !irq_enter && !irq_return)
            |=> $stable(cur_set) && $stable(active_ctx)
    );

    assert_return_restores_R4: assert property (
        @(posedge clk) disable iff (!rst_n)
        (irq_return && !irq_enter && !stk_empty) |=> (active_ctx == $past(stk_top))
    );

    assert_write_lands_R2: assert property (
        @(posedge clk) disable iff (!rst_n)
        (alu_we && !irq_enter && !irq_return) |=> (cur_set == $past(wr_set))
    );

endmodule

// File: tb/irq_flag_ctx_tb.sv
module irq_flag_ctx_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alu_we = 0, alu_ovf = 0, alu_unf = 0, alu_zero = 0;
    logic       irq_enter = 0, irq_return = 0, sub_call = 0, sub_ret = 0;
    logic [1:0] irq_level = 0;
    logic [7:0] rd_addr = 8'h26;
    logic       flag_carry, flag_sign, flag_zero, in_service, ret_err;
    logic [2:0] active_ctx;
    logic [7:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model
    logic [2:0] m_flags [5];   // {zero, sign, carry}
    int         m_stk [5];
    int         m_sp;
    int         m_cur;
    bit         m_err;

    always #5 clk = ~clk;

    irq_flag_ctx u_dut (
        .clk(clk), .rst_n(rst_n), .alu_we(alu_we), .alu_ovf(alu_ovf),
        .alu_unf(alu_unf), .alu_zero(alu_zero), .irq_enter(irq_enter),
        .irq_level(irq_level), .irq_return(irq_return), .sub_call(sub_call),
        .sub_ret(sub_ret), .rd_addr(rd_addr), .flag_carry(flag_carry),
        .flag_sign(flag_sign), .flag_zero(flag_zero), .in_service(in_service),
        .active_ctx(active_ctx), .rd_data(rd_data), .ret_err(ret_err)
    );

    function automatic logic [7:0] exp_read(input logic [7:0] a, input logic [2:0] f);
        return (a == 8'h26) ? {5'b0, f} : 8'h00;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        chk(req, "flags", {flag_zero, flag_sign, flag_carry}, m_flags[m_cur]);
        chk(req, "active_ctx", active_ctx, m_cur);
        chk(req, "in_service", in_service, m_cur != 0);
        chk(req, "ret_err", ret_err, m_err);
        chk(req, "rd_data", rd_data, exp_read(rd_addr, m_flags[m_cur]));
    endtask

    task automatic model_step(input bit we, input bit ov, input bit un, input bit zr,
                              input bit ent, input int lvl, input bit ret);
        if (we) m_flags[m_cur] = {zr, un, ov};
        if (ent) begin
            if (m_sp < 5) begin
                m_stk[m_sp] = m_cur;
                m_sp++;
                m_cur = lvl + 1;
            end
        end else if (ret) begin
            if (m_sp == 0) m_err = 1;
            else begin
                m_sp--;
                m_cur = m_stk[m_sp];
            end
        end
    endtask

    task automatic cycle(input bit we, input bit ov, input bit un, input bit zr,
                         input bit ent, input int lvl, input bit ret,
                         input bit call, input bit sret, input logic [7:0] addr,
                         input string req);
        alu_we = we; alu_ovf = ov; alu_unf = un; alu_zero = zr;
        irq_enter = ent; irq_level = lvl[1:0]; irq_return = ret;
        sub_call = call; sub_ret = sret; rd_addr = addr;
        model_step(we, ov, un, zr, ent, lvl, ret);
        @(negedge clk);
        compare_all(req);
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 5; i++) m_flags[i] = 3'b000;
        m_sp = 0; m_cur = 0; m_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");

        // R2: write in normal mode
        cycle(1, 1, 0, 1, 0, 0, 0, 0, 0, 8'h26, "R2");
        // R6: call/return leave normal flags alone
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 0, 8'h26, "R6");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1, 8'h26, "R6");
        // R3: enter level 2, write its set
        cycle(0, 0, 0, 0, 1, 2, 0, 0, 0, 8'h26, "R3");
        cycle(1, 0, 1, 0, 0, 0, 0, 0, 0, 8'h26, "R2");
        // R4: return to normal, normal flags restored
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h26, "R4");
        // R5: re-enter level 2, its old flags persist
        cycle(0, 0, 0, 0, 1, 2, 0, 0, 0, 8'h26, "R5");
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h26, "R4");
        // R7: stray return
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h26, "R7");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h26, "R7");
        // R9: other address reads zero
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h25, "R9");
        // R8: fill the stack with 5 nested entries, then one more
        for (int k = 0; k < 5; k++)
            cycle(1, k[0], k[1], 1, 1, k % 4, 0, 0, 0, 8'h26, "R8");
        cycle(0, 0, 0, 0, 1, 0, 0, 0, 0, 8'h26, "R8");
        chk("R8", "ctx after full entry", active_ctx, 1);
        // R10: enter and return together, write goes to old context
        for (int k = 0; k < 5; k++)
            cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h26, "R4");
        cycle(1, 1, 1, 1, 1, 3, 1, 0, 0, 8'h26, "R10");
        chk("R10", "ctx after simultaneous", active_ctx, 4);
        cycle(0, 0, 0, 0, 0, 0, 1, 0, 0, 8'h26, "R10");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            bit ent, ret;
            logic [7:0] a;
            ent = ($urandom % 4) == 0;
            ret = ($urandom % 4) == 0;
            a   = (($urandom % 4) == 0) ? 8'($urandom) : 8'h26;
            cycle($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                  ent, $urandom % 4, ret, $urandom % 2, $urandom % 2, a, "R2 R4 R5");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule